// File: doc/BRIEF.md
# Length-prefixed input queue

This block buffers 8-bit elements on their way into a processor. A loader writes bytes one at a time with a write strobe. The first byte of each load is a header, not data. It states how many data elements follow it. A small control machine reads that header and sets a remaining-element count from it. It then moves the read pointer past the header so that the first real element is at the output. After that it serves pops from the consumer.

The consumer sees a data output, an empty flag and a pop strobe. The output shows the current element whenever the queue is not empty, and reads zero otherwise. The empty flag rises once the stated number of elements has been popped. It is also high while the next counted element has not been written yet, so a consumer that wants data simply waits. Storage holds 32 bytes, and the header takes one of them. Writes that arrive when the storage is full are discarded.

Top module: `hdrq_top`

## Requirements
- R1: After synchronous reset `empty` is 1, `rd_data` is 0, and the next byte written is treated as a new header.
- R2: The first byte written after reset is never presented as data. Once loaded, `rd_data` shows the second byte written.
- R3: Each accepted pop (`pop` = 1 while `empty` = 0) advances to the next element, so elements leave in write order.
- R4: Once as many pops have been accepted as the header value states, `empty` stays 1 even if more bytes are stored or written.
- R5: A pop while `empty` = 1 is ignored. No element is skipped, and the next element written is the next one shown.
- R6: A header value of 0 keeps `empty` at 1 and `rd_data` at 0, whatever data bytes follow it.
- R7: Storage holds 32 bytes including the header. Writes that arrive when it is full are dropped, so at most 31 elements can be popped.
- R8: If the header counts more elements than have been written, `empty` rises when the written ones are used up. It falls again when a further byte is written.
- R9: `rd_data` reads 0 in every cycle in which `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Loader write strobe |
| wr_data | input | 8 | Byte written by the loader (header first, then data) |
| pop | input | 1 | Consumer pop strobe |
| rd_data | output | 8 | Current element, or 0 while empty |
| empty | output | 1 | High when no counted element is available |

## Verification
The bench builds the block with its default parameters: 8-bit elements and 32 storage entries. With these values, a header of 40 followed by 39 data bytes is enough to fill the storage and force dropped writes, and an 8-bit header can exceed the 31-element capacity. The small depth also lets the bench load, drain and reload the queue many times. This covers a zero header, a short load, a count below the bytes written, and data that arrives after the consumer has already drained the queue.

// File: rtl/hdrq_pkg.sv
package hdrq_pkg;

    // One-hot control states held in a 3-bit register
    typedef enum logic [2:0] {
        ST_WAIT_HDR = 3'b001,
        ST_LOAD_LEN = 3'b010,
        ST_SERVE    = 3'b100
    } hdrq_state_t;

    // True when an element is available to the consumer
    function automatic logic item_ready(input hdrq_state_t st,
                                        input logic        left_nz,
                                        input logic        behind_wr);
        return (st == ST_SERVE) && left_nz && behind_wr;
    endfunction

endpackage

// File: rtl/hdrq_store.sv
module hdrq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] hdr_word,
    output logic [CW-1:0]     wcnt
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              full;

    assign full = (wcnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
        end else if (wr_en && !full) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_en && !full) begin
            mem[wcnt[AW-1:0]] <= wr_data;
        end
    end

    assign rd_word  = mem[rd_idx];
    assign hdr_word = mem[0];

    // R7: a write into a full store leaves the fill count unchanged
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wcnt == CW'(DEPTH)) |=> $stable(wcnt));

    // R7: fill count never exceeds the storage depth
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
        wcnt <= CW'(DEPTH));

    // R1: the first cycle after reset starts with nothing stored
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wcnt == '0));

endmodule

// File: rtl/hdrq_ctrl.sv
module hdrq_ctrl
    import hdrq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic [CW-1:0]     wcnt,
    input  logic [DATA_W-1:0] hdr,
    output logic [CW-1:0]     rptr,
    output logic              empty
);

    hdrq_state_t       state;
    logic [DATA_W-1:0] remaining;
    logic              take;

    assign empty = !item_ready(state, remaining != '0, rptr < wcnt);
    assign take  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT_HDR;
            remaining <= '0;
            rptr      <= '0;
        end else begin
            unique case (state)
                ST_WAIT_HDR: begin
                    if (wcnt != '0) state <= ST_LOAD_LEN;
                end
                ST_LOAD_LEN: begin
                    remaining <= hdr;
                    rptr      <= CW'(1);
                    state     <= ST_SERVE;
                end
                ST_SERVE: begin
                    if (take) begin
                        remaining <= remaining - 1'b1;
                        rptr      <= rptr + 1'b1;
                    end
                end
                default: state <= ST_WAIT_HDR;
            endcase
        end
    end

    // R1: the state register always holds exactly one state
    p_state_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    // R3: an accepted pop uses up exactly one counted element
    p_pop_dec_r3: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty) |=> (remaining == $past(remaining) - 1'b1));

    // R5: a pop while empty moves neither the pointer nor the count
    p_pop_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SERVE && pop && empty) |=> ($stable(rptr) && $stable(remaining)));

    // R6: a zero header leads straight to empty
    p_zero_hdr_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD_LEN && hdr == '0) |=> empty);

    // R8: the read pointer never passes the write position
    p_rptr_bound_r8: assert property (@(posedge clk) disable iff (rst)
        rptr <= wcnt);

endmodule

// File: rtl/hdrq_top.sv
module hdrq_top #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]     wcnt;
    logic [CW-1:0]     rptr;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] hdr_word;

    hdrq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_idx   (rptr[AW-1:0]),
        .rd_word  (rd_word),
        .hdr_word (hdr_word),
        .wcnt     (wcnt)
    );

    hdrq_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .pop   (pop),
        .wcnt  (wcnt),
        .hdr   (hdr_word),
        .rptr  (rptr),
        .empty (empty)
    );

    assign rd_data = empty ? '0 : rd_word;

endmodule

// File: tb/test_hdrq_top.sv
`timescale 1ns/1ps
module test_hdrq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       empty;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    hdrq_top i_hdrq_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .rd_data (rd_data),
        .empty   (empty)
    );

    // {header, bytes written after header, first data value}
    localparam logic [23:0] VEC [6] = '{
        {8'd3,  8'd3,  8'h10},
        {8'd2,  8'd5,  8'h40},
        {8'd0,  8'd4,  8'h70},
        {8'd40, 8'd39, 8'h80},
        {8'd1,  8'd1,  8'hF0},
        {8'd5,  8'd5,  8'hA0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; pop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 empty after reset", {7'd0, empty}, 8'd1);
        chk("R1 rd_data after reset", rd_data, 8'h00);

        // Vector walk
        for (int v = 0; v < 6; v++) begin
            logic [7:0] hdr, n, base;
            int vis;
            {hdr, n, base} = VEC[v];
            vis = (hdr < n) ? hdr : n;
            if (vis > 31) vis = 31;
            do_reset();
            put(hdr);
            for (int i = 0; i < n; i++) put(base + 8'(i));
            idle(3);
            for (int k = 0; k < vis; k++) begin
                chk("R2/R3 not empty", {7'd0, empty}, 8'd0);
                chk("R2/R3 element order", rd_data, base + 8'(k));
                take();
            end
            chk("R4/R6/R7 empty after count", {7'd0, empty}, 8'd1);
            chk("R9 zero while empty", rd_data, 8'h00);
        end

        // R8 and R5: late data, pops while empty
        do_reset();
        put(8'd3);
        put(8'h11);
        idle(3);
        chk("R8 first element", rd_data, 8'h11);
        take();
        chk("R8 waits for data", {7'd0, empty}, 8'd1);
        take();
        take();
        chk("R5 ignored pop keeps empty", {7'd0, empty}, 8'd1);
        put(8'h22);
        idle(2);
        chk("R8 empty falls on new data", {7'd0, empty}, 8'd0);
        chk("R5 no element skipped", rd_data, 8'h22);
        take();
        put(8'h33);
        idle(1);
        chk("R5 next element", rd_data, 8'h33);
        take();
        put(8'h44);
        idle(2);
        chk("R4 stays empty past count", {7'd0, empty}, 8'd1);
        chk("R9 zero past count", rd_data, 8'h00);

        // R1: reset mid-run, then a fresh header
        put(8'h55);
        do_reset();
        chk("R1 empty after mid-run reset", {7'd0, empty}, 8'd1);
        put(8'd1);
        put(8'h5A);
        idle(3);
        chk("R1 new header after reset", rd_data, 8'h5A);
        take();
        chk("R4 single element drained", {7'd0, empty}, 8'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule